// File: doc/BRIEF.md
# Three-Stage Clos Multiplexer Switching Network

This block is a statically configured three-stage Clos switch C(n, r, m, n, r). It has N = n·r data input ports and N data output ports, arranged in r groups of n. Every node past the inputs is a multiplexer followed by a register. Ingress nodes choose one of the n inputs of their own group. Middle nodes with index t choose one of the r ingress nodes that carry the same index t. Each output chooses one of the m middle nodes that belong to its own group.

The routing is worked out elsewhere and arrives as a flat configuration vector made of one select field per node. Because every stage is registered, a word crosses the network in three clock cycles. Each stage reads its select fields at the edge on which it captures data. Several outputs can read the same upstream node, so one input can reach several outputs at once (multicast). When m ≥ n, any one-to-one routing can be realised with a suitable configuration.

Top module: `clos3_mux_net`

## Requirements
- R1: While `rst_ni` is low, every output word is zero, whatever the data and configuration inputs are.
- R2: Latency is exactly three clock edges. The word on an output after edge e comes from the data input sampled at edge e-2, which is the third edge counting back from e and including e itself.
- R3: Ingress node (j, t), with group j < r and middle index t < m, captures input j·n + s, where s is the value of its select field.
- R4: Middle node (h, t) captures ingress node (g, t), where g is the value of its select field.
- R5: Output j·n + t captures middle node (j, s), where s is the value of its select field.
- R6: Field widths are wi = max(1, ceil(log2 n)), wm = max(1, ceil(log2 r)) and wo = max(1, ceil(log2 m)). In the configuration vector, ingress field (j, t) sits at bit (j·m + t)·wi. Middle field (h, t) sits at r·m·wi + (h·m + t)·wm. Output field (j, t) sits at r·m·(wi + wm) + (j·n + t)·wo. All fields are little-endian.
- R7: Outputs whose selects trace back to the same input all carry that input's word (multicast).
- R8: A select value at or above the fan-in of its node makes that node capture zero.
- R9: The word on an output after edge e follows the output fields sampled at edge e, the middle fields sampled at e-1 and the ingress fields sampled at e-2. A configuration change therefore travels along with the data through the pipeline.
- R10: An all-zero data input gives an all-zero output two edges after the edge that sampled it, whatever the configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | r·m·(wi+wm) + n·r·wo | Packed select fields for all nodes |
| in_data_i | input | n·r·DW | Input port words, port k at bits k·DW |
| out_data_o | output | n·r·DW | Output port words, port k at bits k·DW |

## Verification
A wrong select decode or a wrong piece of topology wiring sends the wrong word, or a zero, to an output. This shows up exactly three edges after the affected data enters. A misplaced pipeline register instead shows up as an output that changes one edge early or late when the data steps. A field read from the wrong stage's configuration sample only shows while the configuration is changing. For this reason, random configurations are changed on every cycle as well as held steady.

// File: rtl/clos_net_pkg.sv
package clos_net_pkg;
  function automatic int sel_w(input int fanin);
    return (fanin <= 1) ? 1 : $clog2(fanin);
  endfunction
endpackage

// File: rtl/clos_mux_reg.sv
module clos_mux_reg #(
  parameter int FANIN = 2,
  parameter int DW    = 8,
  parameter int SW    = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SW-1:0]       sel_i,
  input  logic [FANIN*DW-1:0] d_i,
  output logic [DW-1:0]       q_o
);
  logic [DW-1:0] pick;

  // out-of-range select leaves pick at zero
  always_comb begin
    pick = '0;
    for (int k = 0; k < FANIN; k++) begin
      if (sel_i == SW'(k)) pick = d_i[k*DW +: DW];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= pick;
  end

  assert_zero_pass_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_i == '0) |=> (q_o == '0));

  if ((1 << SW) > FANIN) begin : g_oor_chk
    assert_oor_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i >= SW'(FANIN)) |=> (q_o == '0));
  end
endmodule

// File: rtl/clos_ingress.sv
module clos_ingress #(
  parameter int GN = 2,
  parameter int GR = 2,
  parameter int GM = 3,
  parameter int DW = 8,
  parameter int SW = 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [GR*GM*SW-1:0]   cfg_i,
  input  logic [GN*GR*DW-1:0]   in_i,
  output logic [GR*GM*DW-1:0]   out_o
);
  for (genvar j = 0; j < GR; j++) begin : g_grp
    for (genvar t = 0; t < GM; t++) begin : g_node
      clos_mux_reg #(.FANIN(GN), .DW(DW), .SW(SW)) u_node (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sel_i  (cfg_i[(j*GM+t)*SW +: SW]),
        .d_i    (in_i[j*GN*DW +: GN*DW]),
        .q_o    (out_o[(j*GM+t)*DW +: DW])
      );
    end
  end
endmodule

// File: rtl/clos_middle.sv
module clos_middle #(
  parameter int GR = 2,
  parameter int GM = 3,
  parameter int DW = 8,
  parameter int SW = 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [GR*GM*SW-1:0]   cfg_i,
  input  logic [GR*GM*DW-1:0]   in_i,
  output logic [GR*GM*DW-1:0]   out_o
);
  for (genvar t = 0; t < GM; t++) begin : g_col
    logic [GR*DW-1:0] col;
    // gather ingress node t of every group
    for (genvar g = 0; g < GR; g++) begin : g_gather
      assign col[g*DW +: DW] = in_i[(g*GM+t)*DW +: DW];
    end
    for (genvar h = 0; h < GR; h++) begin : g_node
      clos_mux_reg #(.FANIN(GR), .DW(DW), .SW(SW)) u_node (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sel_i  (cfg_i[(h*GM+t)*SW +: SW]),
        .d_i    (col),
        .q_o    (out_o[(h*GM+t)*DW +: DW])
      );
    end
  end
endmodule

// File: rtl/clos_egress.sv
module clos_egress #(
  parameter int GN = 2,
  parameter int GR = 2,
  parameter int GM = 3,
  parameter int DW = 8,
  parameter int SW = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [GR*GN*SW-1:0]   cfg_i,
  input  logic [GR*GM*DW-1:0]   in_i,
  output logic [GR*GN*DW-1:0]   out_o
);
  for (genvar j = 0; j < GR; j++) begin : g_grp
    for (genvar t = 0; t < GN; t++) begin : g_node
      clos_mux_reg #(.FANIN(GM), .DW(DW), .SW(SW)) u_node (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sel_i  (cfg_i[(j*GN+t)*SW +: SW]),
        .d_i    (in_i[j*GM*DW +: GM*DW]),
        .q_o    (out_o[(j*GN+t)*DW +: DW])
      );
    end
  end
endmodule

// File: rtl/clos3_mux_net.sv
module clos3_mux_net #(
  parameter int GRP_IN  = 2,
  parameter int GRP_NUM = 2,
  parameter int MID_NUM = 3,
  parameter int DW      = 8,
  localparam int PORTS  = GRP_IN * GRP_NUM,
  localparam int S1W    = clos_net_pkg::sel_w(GRP_IN),
  localparam int S2W    = clos_net_pkg::sel_w(GRP_NUM),
  localparam int S3W    = clos_net_pkg::sel_w(MID_NUM),
  localparam int C1_W   = GRP_NUM * MID_NUM * S1W,
  localparam int C2_W   = GRP_NUM * MID_NUM * S2W,
  localparam int C3_W   = PORTS * S3W,
  localparam int CFG_W  = C1_W + C2_W + C3_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [CFG_W-1:0]      cfg_i,
  input  logic [PORTS*DW-1:0]   in_data_i,
  output logic [PORTS*DW-1:0]   out_data_o
);
  localparam int NODES = GRP_NUM * MID_NUM;

  logic [NODES*DW-1:0] s1_q;
  logic [NODES*DW-1:0] s2_q;

  clos_ingress #(.GN(GRP_IN), .GR(GRP_NUM), .GM(MID_NUM), .DW(DW), .SW(S1W)) u_ingress (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cfg_i  (cfg_i[0 +: C1_W]),
    .in_i   (in_data_i),
    .out_o  (s1_q)
  );

  clos_middle #(.GR(GRP_NUM), .GM(MID_NUM), .DW(DW), .SW(S2W)) u_middle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cfg_i  (cfg_i[C1_W +: C2_W]),
    .in_i   (s1_q),
    .out_o  (s2_q)
  );

  clos_egress #(.GN(GRP_IN), .GR(GRP_NUM), .GM(MID_NUM), .DW(DW), .SW(S3W)) u_egress (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cfg_i  (cfg_i[C1_W+C2_W +: C3_W]),
    .in_i   (s2_q),
    .out_o  (out_data_o)
  );

  // edges seen since reset release, for assertion warm-up only
  logic [2:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             warm_q <= '0;
    else if (warm_q != 3'd4) warm_q <= warm_q + 3'd1;
  end

  assert_steady_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q >= 3'd3 && $stable(cfg_i) && $past($stable(cfg_i)) &&
     $past($stable(cfg_i), 2) && $past($stable(in_data_i), 2))
    |=> $stable(out_data_o));

  assert_zero_flow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q >= 3'd2 && $past(in_data_i == '0, 2)) |=> (out_data_o == '0));
endmodule

// File: tb/sim_clos3_mux_net.sv
`timescale 1ns/1ps
module sim_clos3_mux_net;
  localparam int GN  = 2;
  localparam int GR  = 2;
  localparam int GM  = 3;
  localparam int DW  = 8;
  localparam int P   = GN * GR;
  localparam int S1W = (GN <= 1) ? 1 : $clog2(GN);
  localparam int S2W = (GR <= 1) ? 1 : $clog2(GR);
  localparam int S3W = (GM <= 1) ? 1 : $clog2(GM);
  localparam int C1  = GR * GM * S1W;
  localparam int C2  = GR * GM * S2W;
  localparam int C3  = P * S3W;
  localparam int CW  = C1 + C2 + C3;
  localparam int VW  = P * DW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] cfg_d;
  logic [VW-1:0] in_d;
  logic [VW-1:0] out_d;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;
  int nsamp = 0;
  logic [VW-1:0] ih0, ih1, ih2;
  logic [CW-1:0] ch0, ch1, ch2;

  always #10 clk = ~clk;

  clos3_mux_net #(.GRP_IN(GN), .GRP_NUM(GR), .MID_NUM(GM), .DW(DW)) u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cfg_i      (cfg_d),
    .in_data_i  (in_d),
    .out_data_o (out_d)
  );

  function automatic logic [CW-1:0] f_in(logic [CW-1:0] c, int j, int t, int v);
    c[(j*GM+t)*S1W +: S1W] = S1W'(v);
    return c;
  endfunction
  function automatic logic [CW-1:0] f_mid(logic [CW-1:0] c, int h, int t, int v);
    c[C1 + (h*GM+t)*S2W +: S2W] = S2W'(v);
    return c;
  endfunction
  function automatic logic [CW-1:0] f_out(logic [CW-1:0] c, int j, int t, int v);
    c[C1 + C2 + (j*GN+t)*S3W +: S3W] = S3W'(v);
    return c;
  endfunction

  // trace each output back through egress (cc), middle (cb), ingress (ca) fields
  function automatic logic [VW-1:0] model(logic [VW-1:0] din, logic [CW-1:0] ca,
                                          logic [CW-1:0] cb, logic [CW-1:0] cc);
    logic [VW-1:0] r;
    r = '0;
    for (int o = 0; o < P; o++) begin
      int j, s1, s2, s3;
      j  = o / GN;
      s3 = int'(cc[C1 + C2 + o*S3W +: S3W]);
      if (s3 < GM) begin
        s2 = int'(cb[C1 + (j*GM+s3)*S2W +: S2W]);
        if (s2 < GR) begin
          s1 = int'(ca[(s2*GM+s3)*S1W +: S1W]);
          if (s1 < GN) r[o*DW +: DW] = din[(s2*GN+s1)*DW +: DW];
        end
      end
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] perm_exp(logic [VW-1:0] din);
    logic [VW-1:0] r;
    r[0*DW +: DW] = din[1*DW +: DW];
    r[1*DW +: DW] = din[2*DW +: DW];
    r[2*DW +: DW] = din[3*DW +: DW];
    r[3*DW +: DW] = din[0*DW +: DW];
    return r;
  endfunction

  task automatic check(input logic [VW-1:0] act, input logic [VW-1:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a negedge; drives, records the edge, checks at the next negedge
  task automatic step(input logic [VW-1:0] din, input logic [CW-1:0] cfg,
                      input string tag, input bit use_model);
    in_d  = din;
    cfg_d = cfg;
    @(posedge clk);
    ih2 = ih1; ih1 = ih0; ih0 = din;
    ch2 = ch1; ch1 = ch0; ch0 = cfg;
    if (nsamp < 3) nsamp++;
    @(negedge clk);
    if (use_model && nsamp >= 3) check(out_d, model(ih2, ch2, ch1, ch0), tag);
  endtask

  task automatic settle(input logic [VW-1:0] din, input logic [CW-1:0] cfg);
    repeat (3) step(din, cfg, "", 1'b0);
  endtask

  initial begin
    logic [CW-1:0] perm, mc, oor;
    logic [VW-1:0] a, b, exp;
    int unused_seed;
    unused_seed = $urandom(32'h5eed_c105);
    rst_n = 1'b0;
    in_d  = VW'($urandom());
    cfg_d = CW'($urandom());
    ih0 = '0; ih1 = '0; ih2 = '0;
    ch0 = '0; ch1 = '0; ch2 = '0;

    // R1: outputs held at zero during reset
    repeat (3) begin
      @(negedge clk);
      check(out_d, '0, "R1 reset state");
      in_d = VW'($urandom());
    end
    rst_n = 1'b1;

    // R3 R4 R5 R6: directed permutation in0->out3, in1->out0, in2->out1, in3->out2
    perm = '0;
    perm = f_in(perm, 0, 0, 0);  perm = f_in(perm, 0, 1, 1);
    perm = f_in(perm, 1, 0, 0);  perm = f_in(perm, 1, 1, 1);
    perm = f_mid(perm, 1, 0, 0); perm = f_mid(perm, 0, 0, 1);
    perm = f_mid(perm, 0, 1, 0); perm = f_mid(perm, 1, 1, 1);
    perm = f_out(perm, 1, 1, 0); perm = f_out(perm, 0, 1, 0);
    perm = f_out(perm, 0, 0, 1); perm = f_out(perm, 1, 0, 1);
    a = 32'h44_33_22_11;
    settle(a, perm);
    check(out_d, perm_exp(a), "R3 R4 R5 R6 permutation pattern 1");
    a = 32'hff_00_ff_00;
    settle(a, perm);
    check(out_d, perm_exp(a), "R3 R4 R5 R6 permutation pattern 2");
    a = VW'($urandom());
    settle(a, perm);
    check(out_d, perm_exp(a), "R3 R4 R5 R6 permutation random");

    // R2: a data step appears on the third edge, not before
    b = ~a;
    step(b, perm, "", 1'b0);
    check(out_d, perm_exp(a), "R2 latency edge 1");
    step(b, perm, "", 1'b0);
    check(out_d, perm_exp(a), "R2 latency edge 2");
    step(b, perm, "", 1'b0);
    check(out_d, perm_exp(b), "R2 latency edge 3");

    // R7: in2 broadcast to every output
    mc = '0;
    mc = f_in(mc, 1, 0, 0);
    mc = f_mid(mc, 0, 0, 1); mc = f_mid(mc, 1, 0, 1);
    for (int o = 0; o < P; o++) mc = f_out(mc, o / GN, o % GN, 0);
    a = 32'hde_5a_be_ef;
    settle(a, mc);
    check(out_d, {4{a[2*DW +: DW]}}, "R7 multicast of input 2");

    // R8: output 2 (group 1, index 0) given select 3 with only 3 middles
    oor = f_out(perm, 1, 0, 3);
    a = 32'h9a_bc_de_f1;
    settle(a, oor);
    exp = perm_exp(a);
    exp[2*DW +: DW] = '0;
    check(out_d, exp, "R8 out-of-range select gives zero");

    // R3 R4 R5: random fixed routes, random data every cycle
    for (int c = 0; c < 20; c++) begin
      logic [CW-1:0] rc;
      rc = CW'($urandom());
      for (int k = 0; k < 12; k++) step(VW'($urandom()), rc, "R3 R4 R5 random fixed route", 1'b1);
    end

    // R9: configuration and data both change every cycle
    for (int k = 0; k < 400; k++)
      step(VW'($urandom()), CW'($urandom()), "R9 per-stage reconfiguration", 1'b1);

    // R10: zero data under random configuration
    for (int k = 0; k < 6; k++) begin
      logic [CW-1:0] rc;
      rc = CW'($urandom());
      settle('0, rc);
      check(out_d, '0, "R10 zero data gives zero");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule